// File: doc/BRIEF.md
# Parallel Multi-Strip Addressable LED Driver

This block drives a set of single-wire addressable RGB LED strips side by side from one shared frame memory. Before each byte period it reads one color byte per active strip through a synchronous read port. It turns each byte into a 24-slot waveform and shifts every strip out together under one common slot timing. When the last byte of every LED has gone out, all lines stay low for a latch interval longer than 50 µs, and then the frame ends.

A frame starts when `start` is high and both the strip count and the strip length are non-zero. The configuration is captured at that moment. While `start` stays high, frames repeat back to back. `done` pulses once at the end of every latch interval.

The slot timers are replicated, one per group of strips. This keeps the fanout of each timer bounded. All the timers are cleared and enabled together, so they tick in step. While the strip lanes send one byte, the fetch unit prefetches the next byte for every strip. This leaves no gap on any line between one byte and the next.

Top module: `led_strip_fanout`

## Requirements
- R1: Every data bit lasts three slots of SLOT_CYC = CLK_HZ/5,000,000 clock cycles each. A 0 is sent as high for one slot then low for two slots. A 1 is sent as high for two slots then low for one slot.
- R2: Each color byte becomes 24 slots, and bit 7 is sent first.
- R3: Let L be the strip length in LEDs. For strip k, LED n, color c (c = 0,1,2), the byte is read from address base + k·4L + 4n + c. A byte at offset 4n+3 is never read.
- R4: Each bit starts with a rising edge on every enabled strip in the same clock cycle.
- R5: Within a frame, each strip sends exactly 3L bytes. There is no gap between bits or between bytes: the low part of each bit is exactly its encoded length.
- R6: After the last bit, every output stays low for the low part of that bit plus at least LATCH_CYC = CLK_HZ/20,000 + 1 cycles before the next frame.
- R7: After reset, `busy`, `done`, `rd_en` and all outputs are low. `busy` goes high within two cycles of an accepted start. `done` is high for exactly one cycle at the end of each latch interval.
- R8: If `start` is high when a latch interval ends, the next frame begins without a break and `busy` stays high. If `start` is low at that point, `busy` falls in the cycle in which `done` rises.
- R9: Outputs for strip indices at or above the captured strip count stay low at all times.
- R10: When the strip count or the strip length is zero, `start` is ignored: `busy` stays low, no read is issued, and all outputs stay low.
- R11: Every active strip's next byte has been fetched before the lanes load it. This requires MAX_STRIPS + 2 ≤ 24·SLOT_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request; frames repeat while high |
| strip_count | input | CNT_W | Number of active strips (0 means none) |
| strip_len | input | LEN_W | LEDs per strip |
| base_addr | input | ADDR_W | Frame buffer base byte address |
| rd_en | output | 1 | Frame buffer read strobe |
| rd_addr | output | ADDR_W | Frame buffer byte address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | A frame or latch interval is in progress |
| done | output | 1 | One-cycle pulse at the end of each latch interval |
| strip_out | output | MAX_STRIPS | Serial data line per strip |

## Verification
Several properties are checked on every cycle:
- `done` never lasts longer than one cycle.
- The group slot timers always tick together.
- Every lane goes high in the first slot after a load.
- No read occurs while the block is idle.
- The lines stay quiet during the latch interval.
- The prefetch is always complete when the lanes load.

Other behaviour can only be shown by the bench's scenarios. This covers:
- the decoded byte values and the address layout for several strip counts, lengths and base addresses;
- exact bit widths and the absence of gaps across byte boundaries;
- the length of the latch gap;
- auto-restart and stopping;
- silence on unused strips;
- rejection of an empty configuration.

// File: rtl/led_fanout_pkg.sv
package led_fanout_pkg;
   localparam int PAT_W      = 24;
   localparam int BITS       = 8;
   localparam int SLOT_LAST  = PAT_W - 1;

   typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_SEND, ST_LATCH} phase_t;

   // Three slots per bit, first slot always high, last always low, bit 7 first.
   function automatic logic [PAT_W-1:0] expand_byte(input logic [BITS-1:0] b);
      logic [PAT_W-1:0] p;
      for (int i = 0; i < BITS; i++) begin
         p[PAT_W-1-3*i] = 1'b1;
         p[PAT_W-2-3*i] = b[BITS-1-i];
         p[PAT_W-3-3*i] = 1'b0;
      end
      return p;
   endfunction
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
   parameter int SLOT_CYC = 50
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = $clog2(SLOT_CYC);
   localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

   if (SLOT_CYC < 2) begin : g_bad_slot
      $error("slot_timer: SLOT_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || tick)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + CW'(1);
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/strip_fetch.sv
module strip_fetch #(
   parameter int N      = 8,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [ADDR_W-1:0]     first_addr,
   input  logic [ADDR_W-1:0]     stride,
   input  logic [CNT_W-1:0]      count,
   output logic                  rd_en,
   output logic [ADDR_W-1:0]     rd_addr,
   input  logic [7:0]            rd_data,
   output logic                  busy,
   output logic [N-1:0][7:0]     next_bytes
);
   logic              issuing_q, rsp_valid_q;
   logic [CNT_W-1:0]  idx_q, rsp_idx_q;
   logic [ADDR_W-1:0] addr_q;

   assign rd_en   = issuing_q;
   assign rd_addr = addr_q;
   assign busy    = issuing_q | rsp_valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issuing_q   <= 1'b0;
         rsp_valid_q <= 1'b0;
         idx_q       <= '0;
         rsp_idx_q   <= '0;
         addr_q      <= '0;
      end else begin
         rsp_valid_q <= issuing_q;
         rsp_idx_q   <= idx_q;
         if (go) begin
            issuing_q <= 1'b1;
            idx_q     <= '0;
            addr_q    <= first_addr;
         end else if (issuing_q) begin
            idx_q  <= idx_q + CNT_W'(1);
            addr_q <= addr_q + stride;
            if ((idx_q + CNT_W'(1)) == count) issuing_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_bytes <= '0;
      end else if (rsp_valid_q) begin
         for (int i = 0; i < N; i++)
            if (rsp_idx_q == CNT_W'(i)) next_bytes[i] <= rd_data;
      end
   end

   // R3
   fetch_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_q |-> (rsp_idx_q < count));
   // R11
   go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);
endmodule

// File: rtl/strip_lane.sv
module strip_lane
   import led_fanout_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       shift,
   input  logic       enable,
   input  logic [7:0] next_byte,
   output logic       dout
);
   logic [PAT_W-1:0] pat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pat_q <= '0;
      else if (load)   pat_q <= expand_byte(next_byte);
      else if (shift)  pat_q <= {pat_q[PAT_W-2:0], 1'b0};
   end

   assign dout = enable & pat_q[PAT_W-1];

   // R1
   slot_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (dout == enable));
endmodule

// File: rtl/led_strip_fanout.sv
module led_strip_fanout
   import led_fanout_pkg::*;
#(
   parameter int MAX_STRIPS = 8,
   parameter int GROUP_SIZE = 6,
   parameter int LEN_W      = 10,
   parameter int ADDR_W     = 16,
   parameter int CLK_HZ     = 250_000_000,
   localparam int CNT_W     = $clog2(MAX_STRIPS + 1)
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CNT_W-1:0]      strip_count,
   input  logic [LEN_W-1:0]      strip_len,
   input  logic [ADDR_W-1:0]     base_addr,
   output logic                  rd_en,
   output logic [ADDR_W-1:0]     rd_addr,
   input  logic [7:0]            rd_data,
   output logic                  busy,
   output logic                  done,
   output logic [MAX_STRIPS-1:0] strip_out
);
   localparam int SLOT_CYC  = CLK_HZ / 5_000_000;
   localparam int LATCH_CYC = CLK_HZ / 20_000 + 1;
   localparam int LAT_W     = $clog2(LATCH_CYC);
   localparam int LEFT_W    = LEN_W + 2;
   localparam int N_GROUPS  = (MAX_STRIPS + GROUP_SIZE - 1) / GROUP_SIZE;

   if (MAX_STRIPS < 1 || GROUP_SIZE < 1) begin : g_bad_count
      $error("led_strip_fanout: MAX_STRIPS and GROUP_SIZE must be positive");
   end
   if (MAX_STRIPS + 2 > PAT_W * SLOT_CYC) begin : g_bad_fetch
      $error("led_strip_fanout: prefetch cannot finish within one byte period");
   end

   phase_t              phase;
   logic [CNT_W-1:0]    cnt_q;
   logic [ADDR_W-1:0]   base_q, stride_q, foff_q, fetch_base;
   logic [LEFT_W-1:0]   left_q;
   logic [1:0]          fcol_q;
   logic [4:0]          slot_q;
   logic [LAT_W-1:0]    lat_q;
   logic                done_q;
   logic                cfg_ok, latch_end, begin_frame, prime_load, last_slot;
   logic                load, go, fetch_busy;
   logic [N_GROUPS-1:0] group_tick;
   logic [MAX_STRIPS-1:0][7:0] next_bytes;

   assign cfg_ok      = (strip_count != '0) && (strip_len != '0);
   assign latch_end   = (phase == ST_LATCH) && (lat_q == LAT_W'(LATCH_CYC - 1));
   assign begin_frame = start && cfg_ok && ((phase == ST_IDLE) || latch_end);
   assign prime_load  = (phase == ST_PRIME) && !fetch_busy;
   assign last_slot   = (phase == ST_SEND) && group_tick[0] && (slot_q == 5'(SLOT_LAST));
   assign load        = prime_load || (last_slot && (left_q != '0));
   assign go          = begin_frame || (load && (left_q > LEFT_W'(1)));
   assign fetch_base  = begin_frame ? base_addr : base_q + foff_q;
   assign busy        = (phase != ST_IDLE);
   assign done        = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= ST_IDLE;
         cnt_q    <= '0;
         base_q   <= '0;
         stride_q <= '0;
         left_q   <= '0;
         foff_q   <= '0;
         fcol_q   <= '0;
         slot_q   <= '0;
         lat_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= latch_end;
         if (begin_frame) begin
            cnt_q    <= strip_count;
            base_q   <= base_addr;
            stride_q <= ADDR_W'(strip_len) << 2;
            left_q   <= LEFT_W'(strip_len) * LEFT_W'(3);
            foff_q   <= ADDR_W'(1);
            fcol_q   <= 2'd1;
            phase    <= ST_PRIME;
         end else begin
            if (go) begin
               foff_q <= foff_q + ((fcol_q == 2'd2) ? ADDR_W'(2) : ADDR_W'(1));
               fcol_q <= (fcol_q == 2'd2) ? 2'd0 : fcol_q + 2'd1;
            end
            if (load) begin
               left_q <= left_q - LEFT_W'(1);
               slot_q <= '0;
            end else if ((phase == ST_SEND) && group_tick[0]) begin
               slot_q <= slot_q + 5'd1;
            end
            case (phase)
               ST_PRIME: if (prime_load) phase <= ST_SEND;
               ST_SEND:  if (last_slot && (left_q == '0)) begin
                            phase <= ST_LATCH;
                            lat_q <= '0;
                         end
               ST_LATCH: if (latch_end) phase <= ST_IDLE;
                         else           lat_q <= lat_q + LAT_W'(1);
               default: ;
            endcase
         end
      end
   end

   strip_fetch #(.N(MAX_STRIPS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(go), .first_addr(fetch_base),
      .stride(stride_q), .count(cnt_q), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(fetch_busy), .next_bytes(next_bytes)
   );

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_timer
      slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
         .clk(clk), .rst_n(rst_n), .run(phase == ST_SEND), .tick(group_tick[g])
      );
   end

   for (genvar k = 0; k < MAX_STRIPS; k++) begin : g_lane
      localparam int G = k / GROUP_SIZE;
      strip_lane u_lane (
         .clk(clk), .rst_n(rst_n), .load(load),
         .shift((phase == ST_SEND) && group_tick[G]),
         .enable(CNT_W'(k) < cnt_q), .next_byte(next_bytes[k]),
         .dout(strip_out[k])
      );
   end

   // R11
   fetch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (phase == ST_SEND)) |-> !fetch_busy);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_LATCH) |-> (strip_out == '0));
   // R10
   idle_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_IDLE) |-> !rd_en);
   // R4
   group_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (group_tick == '0) || (&group_tick));
endmodule

// File: tb/led_strip_fanout_bench.sv
module led_strip_fanout_bench;
   localparam int MAXS   = 8;
   localparam int CLK_HZ = 50_000_000;   // scaled timing keeps runs short
   localparam int CNT_W  = $clog2(MAXS + 1);
   localparam int SLOT   = CLK_HZ / 5_000_000;
   localparam int LATCH  = CLK_HZ / 20_000 + 1;
   // {strip count, LEDs per strip, base address, frames}
   localparam int CFG [3][4] = '{'{8, 2, 'h0100, 2}, '{3, 3, 'h0400, 2}, '{1, 1, 'h0ff0, 3}};

   logic clk = 1'b0, rst_n, start;
   logic [CNT_W-1:0] strip_count;
   logic [9:0]  strip_len;
   logic [15:0] base_addr, rd_addr;
   logic [7:0]  rd_data;
   logic rd_en, busy, done;
   logic [MAXS-1:0] strip_out;

   always #2 clk = ~clk;

   led_strip_fanout #(.MAX_STRIPS(MAXS), .CLK_HZ(CLK_HZ)) u_led_strip_fanout (
      .clk(clk), .rst_n(rst_n), .start(start), .strip_count(strip_count),
      .strip_len(strip_len), .base_addr(base_addr), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
      .strip_out(strip_out)
   );

   int checks = 0, fails = 0;
   bit finished = 0, mon_on = 0;
   int cur_cnt = 0, cur_len = 0, cur_base = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] memval(input logic [15:0] a);
      return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] exp_byte(input int k, input int i);
      int a = cur_base + k * cur_len * 4 + (i / 3) * 4 + (i % 3);
      return memval(16'(a));
   endfunction

   // frame memory model and read-address monitor
   int reads = 0, bad_rd = 0;
   always @(posedge clk) begin
      if (rd_en) rd_data <= memval(rd_addr);
      if (!mon_on) begin
         reads = 0; bad_rd = 0;
      end else if (rd_en) begin
         reads++;
         if (((int'(rd_addr) - cur_base) & 3) == 3) bad_rd++;
      end
   end

   // per-strip waveform decoder
   int hi[MAXS], lo[MAXS], nb[MAXS], nby[MAXS], fr[MAXS], explow[MAXS];
   bit live[MAXS];
   logic [7:0] sh[MAXS];
   logic [MAXS-1:0] prev, rises, en_mask;
   int dones = 0, wide = 0, r9_bad = 0, lock_bad = 0;
   bit done_prev = 0;

   always @(negedge clk) begin
      if (!mon_on) begin
         for (int k = 0; k < MAXS; k++) begin
            hi[k] = 0; lo[k] = 0; nb[k] = 0; nby[k] = 0; fr[k] = 0;
            explow[k] = 0; live[k] = 0; sh[k] = '0;
         end
         prev = '0; dones = 0; wide = 0; r9_bad = 0; lock_bad = 0; done_prev = 0;
      end else begin
         rises = '0;
         en_mask = MAXS'((1 << cur_cnt) - 1);
         for (int k = 0; k < MAXS; k++) begin
            if (k >= cur_cnt) begin
               if (strip_out[k]) r9_bad++;
            end else if (strip_out[k] && !prev[k]) begin
               rises[k] = 1'b1;
               if (live[k] && lo[k] != explow[k]) begin
                  chk(lo[k] >= explow[k] + LATCH, "R6 latch gap", lo[k], explow[k] + LATCH);
                  chk(nby[k] == 3 * cur_len && nb[k] == 0, "R5 R11 bytes per frame", nby[k], 3 * cur_len);
                  fr[k]++; nby[k] = 0; nb[k] = 0;
               end
               live[k] = 1; hi[k] = 1;
            end else if (strip_out[k]) begin
               hi[k]++;
            end else if (prev[k]) begin
               chk(hi[k] == SLOT || hi[k] == 2 * SLOT, "R1 high width", hi[k], SLOT);
               explow[k] = (hi[k] == 2 * SLOT) ? SLOT : 2 * SLOT;
               sh[k] = {sh[k][6:0], hi[k] == 2 * SLOT};
               lo[k] = 1; nb[k]++;
               if (nb[k] == 8) begin
                  chk(sh[k] == exp_byte(k, nby[k]), "R2 R3 byte value", sh[k], exp_byte(k, nby[k]));
                  nby[k]++; nb[k] = 0;
               end
            end else begin
               lo[k]++;
            end
         end
         if (rises != '0 && rises != en_mask) lock_bad++;
         if (done) begin
            dones++;
            if (done_prev) wide++;
         end
         done_prev = done;
         prev = strip_out;
      end
   end

   task automatic run_cfg(input int c, input int l, input int b, input int nf);
      mon_on = 0;
      cur_cnt = c; cur_len = l; cur_base = b;
      strip_count = CNT_W'(c); strip_len = 10'(l); base_addr = 16'(b);
      @(negedge clk);
      mon_on = 1;
      start = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      while (dones < nf - 1) @(negedge clk);
      chk(busy == 1'b1, "R8 busy across restart", busy, 1);
      start = 1'b0;
      while (dones < nf) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R8 idle after stop", busy, 0);
      chk(fr[0] + 1 == nf, "R8 frame count", fr[0] + 1, nf);
      for (int k = 0; k < c; k++)
         chk(nby[k] == 3 * l, "R5 last frame bytes", nby[k], 3 * l);
      chk(r9_bad == 0, "R9 unused strips low", r9_bad, 0);
      chk(lock_bad == 0, "R4 lockstep rises", lock_bad, 0);
      chk(bad_rd == 0, "R3 skipped byte read", bad_rd, 0);
      chk(wide == 0, "R7 done width", wide, 0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; strip_count = '0; strip_len = '0; base_addr = '0;
      repeat (3) @(negedge clk);
      // R7 reset state
      chk(busy == 1'b0 && done == 1'b0, "R7 reset busy/done", {busy, done}, 0);
      chk(strip_out == '0 && rd_en == 1'b0, "R7 reset outputs", strip_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int t = 0; t < 3; t++) run_cfg(CFG[t][0], CFG[t][1], CFG[t][2], CFG[t][3]);

      // R10 empty configuration ignored
      mon_on = 0; cur_cnt = 0;
      strip_count = '0; strip_len = 10'd3; @(negedge clk);
      mon_on = 1; start = 1'b1;
      repeat (40) @(negedge clk);
      chk(busy == 1'b0 && reads == 0, "R10 zero count", reads, 0);
      strip_count = CNT_W'(2); strip_len = '0;
      repeat (40) @(negedge clk);
      chk(busy == 1'b0 && reads == 0, "R10 zero length", reads, 0);
      chk(r9_bad == 0, "R10 outputs low", r9_bad, 0);
      start = 1'b0;

      // R7 reset in mid-frame
      mon_on = 0;
      strip_count = CNT_W'(2); strip_len = 10'd1; start = 1'b1;
      repeat (300) @(negedge clk);
      rst_n = 1'b0; start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0 && rd_en == 1'b0 && strip_out == '0, "R7 mid-frame reset", strip_out, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200_000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(1'b0, "watchdog", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule